// File: doc/BRIEF.md
# SPI Peripheral Bring-Up Sequencer

This block sits on the controller side of a serial link to a register peripheral whose frames are protected by a CRC byte. It runs the peripheral's fixed initialisation sequence after a start request. The sequence is a two-key software reset, a calibration-memory refresh, a write that clears the peripheral's reset-occurred flag, and, if requested, a write that turns the peripheral's CRC checking off. Bit shifting is done by a separate SPI master. This block hands that master one 32-bit word per frame and then waits until the master reports that the word has been shifted out.

Each frame is a 24-bit payload followed by a CRC-8 byte. The sequencer computes that byte from the payload in hardware. CRC checking in the peripheral stays active until the last frame, so every frame the sequencer sends carries a CRC byte. After the second reset key and after the refresh, the sequencer waits a configurable number of clocks so the peripheral can settle. It raises a one-cycle done pulse when the last frame completes. If the master stays busy too long, it raises an error and abandons the run.

Words go to the master over a valid/ready stream:
- The sequencer raises `frame_valid_o` and holds `frame_word_o` unchanged until a clock edge where `frame_ready_i` is also high. That edge is the handshake.
- The master may hold ready low for any number of cycles; this is back-pressure.
- From the cycle after the handshake, the master holds `spi_busy_i` high until the word has been shifted out.
- The sequencer offers the next word only after it has seen `spi_busy_i` low.

Top module: `spi_bringup_seq`

## Requirements
- R1: While reset is held, and after it is released, `frame_valid_o`, `done_o`, `err_o` and `active_o` are all low.
- R2: After a start, the frames go out in this fixed order: reset key one (payload 0x8815FA), reset key two (0x88FA51), calibration refresh (0x88FCBA), reset-flag clear (0x142000), and optionally CRC disable (0x50005C).
- R3: Each 32-bit word is the 24-bit payload in bits 31:8 and a CRC-8 byte in bits 7:0. The CRC uses polynomial 0x07 with an initial value of zero and takes the payload MSB first. As a result, the first word is 0x8815FAA4 and the CRC-disable word is 0x50005CB7.
- R4: While `frame_valid_o` is high and `frame_ready_i` is low, the word stays unchanged. A new word is offered only after `spi_busy_i` has been seen low following the previous handshake.
- R5: After the second reset key and after the calibration refresh complete, the next word is offered SETTLE_CYC+1 cycles after busy falls. After any other frame, it is offered one cycle after busy falls.
- R6: `crc_off_i` is sampled when a start is accepted. If it is 1, the CRC-disable frame is appended as the fifth frame; if it is 0, the run ends after four frames.
- R7: `done_o` pulses for exactly one cycle, once per run, in the cycle after the last frame's busy is seen low.
- R8: If `spi_busy_i` is seen high for TMO_CYC consecutive cycles during a transfer, `err_o` goes high, no further frame is offered and no done pulse follows. `err_o` stays high until the next accepted start.
- R9: A start request while a run is active is ignored: the run continues with the same frame count and gives a single done pulse.
- R10: `active_o` is high from the cycle after an accepted start until the run ends with done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the sequence; acted on only when idle |
| crc_off_i | input | 1 | 1 = append the CRC-disable frame at the end |
| frame_valid_o | output | 1 | A word is offered to the SPI master |
| frame_ready_i | input | 1 | The SPI master accepts the offered word |
| frame_word_o | output | 32 | Word to shift: payload in bits 31:8, CRC in bits 7:0 |
| spi_busy_i | input | 1 | The SPI master is shifting the accepted word |
| active_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run completes |
| err_o | output | 1 | A transfer timed out; held until the next start |

## Verification
A wrong frame index or a wrong CRC computation shows up as a wrong word on `frame_word_o` at the very next handshake. A wrong state decode shows up as a wrong gap between the fall of busy and the next valid, measured to the exact cycle. A miscounted last index shows up as a missing or extra frame, or as a misplaced done pulse, within one cycle of the final busy fall. Timeout handling is checked at its boundary: a transfer one cycle shorter than the limit must complete normally, and a transfer exactly at the limit must raise the error.

// File: rtl/spi_bringup_pkg.sv
package spi_bringup_pkg;
  localparam int PAYLOAD_W = 24;
  localparam int CRC_W     = 8;
  localparam int WORD_W    = PAYLOAD_W + CRC_W;
  localparam int NUM_STEPS = 5;
  localparam int IDX_W     = $clog2(NUM_STEPS);

  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SEND   = 2'd1,
    SQ_XFER   = 2'd2,
    SQ_SETTLE = 2'd3
  } seq_state_t;

  typedef enum logic [IDX_W-1:0] {
    STEP_KEY_A   = 3'd0,
    STEP_KEY_B   = 3'd1,
    STEP_REFRESH = 3'd2,
    STEP_CLR_FLG = 3'd3,
    STEP_CRC_OFF = 3'd4
  } step_t;
endpackage

// File: rtl/sbs_crc8.sv
module sbs_crc8 #(
  parameter int DW = 24,
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [DW-1:0] data_i,
  output logic [7:0]    crc_o
);
  always_comb begin
    logic [7:0] acc;
    logic       fb;
    acc = 8'h00;
    for (int b = DW - 1; b >= 0; b--) begin
      fb  = acc[7] ^ data_i[b];
      acc = {acc[6:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    crc_o = acc;
  end
endmodule

// File: rtl/sbs_frame_sel.sv
module sbs_frame_sel
  import spi_bringup_pkg::*;
(
  input  logic [IDX_W-1:0]     idx_i,
  output logic [PAYLOAD_W-1:0] payload_o
);
  always_comb begin
    unique case (idx_i)
      STEP_KEY_A:   payload_o = 24'h8815FA;
      STEP_KEY_B:   payload_o = 24'h88FA51;
      STEP_REFRESH: payload_o = 24'h88FCBA;
      STEP_CLR_FLG: payload_o = 24'h142000;
      STEP_CRC_OFF: payload_o = 24'h50005C;
      default:      payload_o = '0;
    endcase
  end
endmodule

// File: rtl/sbs_timer.sv
module sbs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_bringup_seq.sv
module spi_bringup_seq
  import spi_bringup_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int TMO_CYC    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        crc_off_i,
  output logic        frame_valid_o,
  input  logic        frame_ready_i,
  output logic [31:0] frame_word_o,
  input  logic        spi_busy_i,
  output logic        active_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int MAXW = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int TW   = $clog2(MAXW + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] TMO_LD    = TW'(TMO_CYC - 1);

  seq_state_t st_q;
  logic [IDX_W-1:0] idx_q;
  logic             crc_off_q;
  logic             done_q, err_q;
  logic             tm_load, tm_dec, tm_zero;
  logic [TW-1:0]    tm_val;
  logic [PAYLOAD_W-1:0] payload;
  logic [CRC_W-1:0]     crc;
  logic             last_step, settle_step;

  sbs_frame_sel u_sel (.idx_i(idx_q), .payload_o(payload));

  sbs_crc8 #(.DW(PAYLOAD_W), .POLY(CRC_POLY)) u_crc (.data_i(payload), .crc_o(crc));

  sbs_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tm_load), .load_val_i(tm_val),
    .dec_i(tm_dec), .zero_o(tm_zero)
  );

  assign last_step   = crc_off_q ? (idx_q == IDX_W'(STEP_CRC_OFF))
                                 : (idx_q == IDX_W'(STEP_CLR_FLG));
  assign settle_step = (idx_q == IDX_W'(STEP_KEY_B)) || (idx_q == IDX_W'(STEP_REFRESH));

  always_comb begin
    tm_load = 1'b0;
    tm_val  = TMO_LD;
    tm_dec  = 1'b0;
    unique case (st_q)
      SQ_SEND:   if (frame_ready_i) tm_load = 1'b1;
      SQ_XFER: begin
        if (!spi_busy_i && settle_step && !last_step) begin
          tm_load = 1'b1;
          tm_val  = SETTLE_LD;
        end else begin
          tm_dec = spi_busy_i;
        end
      end
      SQ_SETTLE: tm_dec = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      idx_q     <= '0;
      crc_off_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q      <= SQ_SEND;
          idx_q     <= '0;
          crc_off_q <= crc_off_i;
          err_q     <= 1'b0;
        end
        SQ_SEND: if (frame_ready_i) st_q <= SQ_XFER;
        SQ_XFER: begin
          if (!spi_busy_i) begin
            if (last_step) begin
              st_q   <= SQ_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= settle_step ? SQ_SETTLE : SQ_SEND;
            end
          end else if (tm_zero) begin
            st_q  <= SQ_IDLE;
            err_q <= 1'b1;
          end
        end
        SQ_SETTLE: if (tm_zero) st_q <= SQ_SEND;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign frame_valid_o = (st_q == SQ_SEND);
  assign frame_word_o  = {payload, crc};
  assign active_o      = (st_q != SQ_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R4
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o && !frame_ready_i |=> frame_valid_o && $stable(frame_word_o));
  // R4
  no_offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o && frame_ready_i |=> !frame_valid_o);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !frame_valid_o && !done_o);
  // R10
  idle_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || $rose(err_o)) |-> !active_o);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o && start_i && !frame_valid_o && !spi_busy_i |=> active_o || done_o || err_o);
endmodule

// File: tb/tb_spi_bringup_seq.sv
module tb_spi_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;
  localparam int TMO    = 12;
  localparam int NVEC   = 5;

  // vector fields: crc_off, busy length, ready stall, expect error
  localparam logic        V_OFF   [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_LEN   [NVEC] = '{3, 1, TMO - 1, TMO, 5};
  localparam int          V_STALL [NVEC] = '{0, 2, 0, 0, 5};
  localparam logic        V_ERR   [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n, start_i, crc_off_i, frame_ready_i, spi_busy_i;
  logic frame_valid_o, active_o, done_o, err_o;
  logic [31:0] frame_word_o;

  int checks = 0, fails = 0;
  int busy_len = 3, stall_len = 0;
  logic [31:0] words [8];
  int gaps [8];
  int nwords = 0, ndone = 0, holdbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bringup_seq #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .crc_off_i(crc_off_i),
    .frame_valid_o(frame_valid_o), .frame_ready_i(frame_ready_i),
    .frame_word_o(frame_word_o), .spi_busy_i(spi_busy_i),
    .active_o(active_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_word(input int k);
    logic [23:0] p;
    case (k)
      0: p = 24'h8815FA;
      1: p = 24'h88FA51;
      2: p = 24'h88FCBA;
      3: p = 24'h142000;
      default: p = 24'h50005C;
    endcase
    return {p, ref_crc(p)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // SPI master model and monitor, all on the falling edge
  initial begin
    int cnt = 0, stall = 0, neg = 0, last_end = 0;
    logic hs_prev = 1'b0, vprev = 1'b0, hold_prev = 1'b0;
    logic [31:0] wprev = '0, whold = '0;
    frame_ready_i = 1'b0;
    spi_busy_i    = 1'b0;
    forever begin
      @(negedge clk);
      neg++;
      if (hold_prev && frame_valid_o && frame_word_o !== whold) holdbad++;
      if (done_o) ndone++;
      if (frame_valid_o && !vprev && nwords < 8) gaps[nwords] = neg - last_end;
      vprev = frame_valid_o;
      if (hs_prev) begin
        if (nwords < 8) words[nwords] = wprev;
        nwords++;
        spi_busy_i = 1'b1;
        cnt = busy_len;
        stall = 0;
      end else if (spi_busy_i) begin
        cnt--;
        if (cnt <= 0) begin
          spi_busy_i = 1'b0;
          last_end = neg;
        end
      end
      if (!rst_n) begin
        spi_busy_i = 1'b0;
        cnt = 0;
      end
      if (frame_valid_o && !spi_busy_i && !hs_prev) stall++;
      frame_ready_i = frame_valid_o && !spi_busy_i && !hs_prev && (stall > stall_len);
      hold_prev = frame_valid_o && !frame_ready_i;
      whold = frame_word_o;
      hs_prev = frame_valid_o && frame_ready_i;
      wprev = frame_word_o;
    end
  end

  task automatic run_seq(input logic off, input int len, input int stl,
                         input logic exp_err, input logic restart);
    int nexp, guard;
    busy_len = len; stall_len = stl;
    nwords = 0; ndone = 0; holdbad = 0;
    @(negedge clk);
    crc_off_i = off; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R8 err cleared by start", {31'd0, err_o}, 32'd0);
    check("R10 active after start", {31'd0, active_o}, 32'd1);
    guard = 0;
    while (!done_o && !err_o && guard < 2000) begin
      if (restart && nwords == 2) start_i = 1'b1;  // R9 stray start
      @(negedge clk);
      start_i = 1'b0;
      guard++;
    end
    if (guard >= 2000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
    end
    repeat (4) @(negedge clk);
    nexp = exp_err ? 1 : (off ? 5 : 4);
    check("R2 R6 frame count", nwords, nexp);
    for (int k = 0; k < nexp && k < 8; k++) begin
      check("R2 R3 frame word", words[k], ref_word(k));
      if (k > 0)
        check("R5 gap after busy", gaps[k], (k == 2 || k == 3) ? SETTLE + 1 : 1);
    end
    check("R7 done count", ndone, exp_err ? 0 : 1);
    check("R8 error flag", {31'd0, err_o}, {31'd0, exp_err});
    check("R4 word hold", holdbad, 0);
    check("R10 idle after end", {31'd0, active_o}, 32'd0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 150000) begin @(posedge clk); wd++; end
        fails++;
        $display("FAIL watchdog: global timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; crc_off_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", {31'd0, frame_valid_o}, 32'd0);
    check("R1 active in reset", {31'd0, active_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {31'd0, done_o}, 32'd0);
    check("R1 err after reset", {31'd0, err_o}, 32'd0);
    // R3 known words
    check("R3 first word literal", ref_word(0), 32'h8815FAA4);
    check("R3 disable word literal", ref_word(4), 32'h50005CB7);

    for (int v = 0; v < NVEC; v++)
      run_seq(V_OFF[v], V_LEN[v], V_STALL[v], V_ERR[v], 1'b0);

    // R9 start while running
    run_seq(1'b0, 4, 1, 1'b0, 1'b1);

    // R1 reset in mid run
    busy_len = 30; stall_len = 0; nwords = 0;
    @(negedge clk); start_i = 1'b1; crc_off_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 active after mid reset", {31'd0, active_o}, 32'd0);
    check("R1 valid after mid reset", {31'd0, frame_valid_o}, 32'd0);
    repeat (3) @(negedge clk);
    run_seq(1'b1, 2, 0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule